// File: doc/BRIEF.md
# Two-Word Parallel Result Port

This block keeps one selected 32-bit result register on view at all times over a 16-bit parallel bus. A free-running sequence counter divides time into frames of two word slots. At the end of each frame the block takes one sample of the selected register. It then sends that sample as a low word followed by a high word. A half-select output shows which word is on the bus. A one-clock strobe marks the cycle in which both byte lanes of the current word hold their final value.

Switching noise is reduced by staggering the byte lanes. The lower byte lane changes on the first clock of a word slot, and the upper byte lane follows one clock later. A serial control block selects the register by pulsing a load input together with an address. The new address is used from the next frame boundary onward, so a word pair is never split between two registers. After reset the register at address 0 is shown.

Top module: `par_result_port`

## Requirements
- R1: While reset is asserted, `bus_data_o` is 0, `word_hi_o` is 0 and `bus_strb_o` is 0.
- R2: After reset is released, and before any selection is loaded, the pairs show the register at address 0, which occupies bits [31:0] of `regs_i`.
- R3: Each pair sends the low word first, with bits [15:0] and `word_hi_o` = 0. The high word follows, with bits [31:16] and `word_hi_o` = 1. The bus bit k carries bit k of the word.
- R4: `bus_strb_o` is high for exactly one clock per word, with `bus_data_o` and `word_hi_o` unchanged from the previous clock. Strobes come every `SLOT_CYCLES` clocks and alternate between low and high words.
- R5: In the first clock of a new word, `bus_data_o[7:0]` and `word_hi_o` already hold the new word. `bus_data_o[15:8]` still holds the upper byte of the previous word, and it takes the new value one clock later.
- R6: Both words of a pair come from one sample taken at the frame boundary. A change of the selected register after that sample does not alter the high word of the same pair, and the change shows up in the next pair.
- R7: A selection loaded through `sel_load_i`/`sel_addr_i` in the middle of a pair leaves the remaining word of that pair unchanged. The selection applies from the next pair onward.
- R8: When several selections are loaded within one frame, the last one loaded before the frame boundary decides the next pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regs_i | input | NUM_REGS*32 | Read register values; register n at bits [32n+31:32n] |
| sel_load_i | input | 1 | One-clock pulse that loads a new register selection |
| sel_addr_i | input | $clog2(NUM_REGS) | Register address captured by `sel_load_i` |
| bus_data_o | output | 16 | Parallel data word |
| word_hi_o | output | 1 | 0 while the low word is on the bus, 1 for the high word |
| bus_strb_o | output | 1 | One-clock mark that both byte lanes are valid |

## Verification
The bench targets the clock that follows a word change. A design that moves both byte lanes together would already show the new upper byte there, when the previous upper byte is expected. It also changes the source register and the selection after the low word has been strobed. A design that reads the register live, or applies the address at once, would send a high word from a different sample or a different register than the low word. Two selections loaded in one frame expose a design that keeps the first one. The strobe is checked for its width, its word order and the settled data under it, which catches a strobe raised while the upper lane is still stale.

// File: rtl/par_result_port_pkg.sv
package par_result_port_pkg;

  localparam int RES_W  = 32;
  localparam int BUS_W  = RES_W / 2;
  localparam int LANE_W = BUS_W / 2;

  typedef logic [RES_W-1:0]  result_t;
  typedef logic [BUS_W-1:0]  bus_word_t;
  typedef logic [LANE_W-1:0] lane_t;

  // one bit per scheduled action of the sequence counter
  typedef struct packed {
    logic wrap;     // frame boundary: take sample, adopt pending address
    logic lo_load;  // lower byte lane and word indicator update
    logic hi_load;  // upper byte lane update
    logic strb_set; // raise strobe for the next clock
    logic word;     // 0 = low word slot, 1 = high word slot
  } seq_ev_t;

  // word of a sample chosen by the slot
  function automatic bus_word_t word_of(input result_t smp, input logic hi);
    return hi ? smp[RES_W-1:BUS_W] : smp[BUS_W-1:0];
  endfunction

  // byte lane of a bus word
  function automatic lane_t lane_of(input bus_word_t w, input logic upper);
    return upper ? w[BUS_W-1:LANE_W] : w[LANE_W-1:0];
  endfunction

endpackage

// File: rtl/prp_seq_counter.sv
module prp_seq_counter
  import par_result_port_pkg::*;
#(
  parameter int SLOT_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  output seq_ev_t ev_o
);

  localparam int PH_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYCLES - 1);
  localparam logic [PH_W-1:0] PH_LO   = PH_W'(0);
  localparam logic [PH_W-1:0] PH_HI   = PH_W'(1);
  localparam logic [PH_W-1:0] PH_STB  = PH_W'(2);

  logic [PH_W-1:0] phase_q;
  logic            word_q;

  // reset lands on the last clock of a frame so a sample is taken at once
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_LAST;
      word_q  <= 1'b1;
    end else if (phase_q == PH_LAST) begin
      phase_q <= PH_LO;
      word_q  <= ~word_q;
    end else begin
      phase_q <= phase_q + PH_W'(1);
    end
  end

  always_comb begin
    ev_o.wrap     = (phase_q == PH_LAST) && word_q;
    ev_o.lo_load  = (phase_q == PH_LO);
    ev_o.hi_load  = (phase_q == PH_HI);
    ev_o.strb_set = (phase_q == PH_STB);
    ev_o.word     = word_q;
  end

endmodule

// File: rtl/prp_sample_select.sv
module prp_sample_select
  import par_result_port_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGS*RES_W-1:0] regs_i,
  input  logic                      sel_load_i,
  input  logic [ADDR_W-1:0]         sel_addr_i,
  input  logic                      wrap_i,
  output logic [ADDR_W-1:0]         act_addr_o,
  output result_t                   sample_o
);

  logic [ADDR_W-1:0] pend_addr_q;
  logic [ADDR_W-1:0] act_addr_q;
  result_t           sample_q;
  result_t           pick;

  // register read; an address beyond the bank reads as zero
  always_comb begin
    pick = '0;
    for (int n = 0; n < NUM_REGS; n++) begin
      if (pend_addr_q == ADDR_W'(n)) pick = regs_i[n*RES_W +: RES_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_addr_q <= '0;
    end else if (sel_load_i) begin
      pend_addr_q <= sel_addr_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_addr_q <= '0;
      sample_q   <= '0;
    end else if (wrap_i) begin
      act_addr_q <= pend_addr_q;
      sample_q   <= pick;
    end
  end

  assign act_addr_o = act_addr_q;
  assign sample_o   = sample_q;

endmodule

// File: rtl/prp_lane_driver.sv
module prp_lane_driver
  import par_result_port_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  seq_ev_t   ev_i,
  input  result_t   sample_i,
  output bus_word_t data_o,
  output logic      word_hi_o,
  output logic      strb_o
);

  bus_word_t cur_word;
  lane_t     lo_q;
  lane_t     hi_q;
  logic      word_hi_q;
  logic      strb_q;

  assign cur_word = word_of(sample_i, ev_i.word);

  // lower lane and indicator move first
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q      <= '0;
      word_hi_q <= 1'b0;
    end else if (ev_i.lo_load) begin
      lo_q      <= lane_of(cur_word, 1'b0);
      word_hi_q <= ev_i.word;
    end
  end

  // upper lane trails by one clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (ev_i.hi_load) begin
      hi_q <= lane_of(cur_word, 1'b1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= ev_i.strb_set;
  end

  assign data_o    = {hi_q, lo_q};
  assign word_hi_o = word_hi_q;
  assign strb_o    = strb_q;

endmodule

// File: rtl/par_result_port.sv
module par_result_port
  import par_result_port_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int SLOT_CYCLES = 4,
  localparam int ADDR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_REGS*RES_W-1:0] regs_i,
  input  logic                      sel_load_i,
  input  logic [ADDR_W-1:0]         sel_addr_i,
  output logic [BUS_W-1:0]          bus_data_o,
  output logic                      word_hi_o,
  output logic                      bus_strb_o
);

  // named internal events, also watched by the bound checker
  seq_ev_t           seq_ev;
  logic              wrap_ev;
  logic              lo_ev;
  logic              hi_ev;
  logic [ADDR_W-1:0] act_addr;
  result_t           sample;

  prp_seq_counter #(
    .SLOT_CYCLES(SLOT_CYCLES)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .ev_o (seq_ev)
  );

  assign wrap_ev = seq_ev.wrap;
  assign lo_ev   = seq_ev.lo_load;
  assign hi_ev   = seq_ev.hi_load;

  prp_sample_select #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .regs_i    (regs_i),
    .sel_load_i(sel_load_i),
    .sel_addr_i(sel_addr_i),
    .wrap_i    (wrap_ev),
    .act_addr_o(act_addr),
    .sample_o  (sample)
  );

  prp_lane_driver u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (seq_ev),
    .sample_i (sample),
    .data_o   (bus_data_o),
    .word_hi_o(word_hi_o),
    .strb_o   (bus_strb_o)
  );

endmodule

// File: rtl/par_result_port_chk.sv
module par_result_port_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       bus_data_o,
  input logic              word_hi_o,
  input logic              bus_strb_o,
  input logic              wrap_ev,
  input logic              lo_ev,
  input logic              hi_ev,
  input logic [ADDR_W-1:0] act_addr,
  input logic [31:0]       sample
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (bus_data_o == 16'h0) && !word_hi_o && !bus_strb_o); // R1

  AST_STRB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strb_o |=> !bus_strb_o); // R4

  AST_STRB_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strb_o |-> $stable(bus_data_o) && $stable(word_hi_o)); // R4

  AST_LO_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_ev |=> $stable(bus_data_o[7:0]) && $stable(word_hi_o)); // R5

  AST_HI_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_ev |=> $stable(bus_data_o[15:8])); // R5

  AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_ev |=> $stable(sample)); // R6

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_ev |=> $stable(act_addr)); // R7

endmodule

bind par_result_port par_result_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_data_o(bus_data_o),
  .word_hi_o (word_hi_o),
  .bus_strb_o(bus_strb_o),
  .wrap_ev   (wrap_ev),
  .lo_ev     (lo_ev),
  .hi_ev     (hi_ev),
  .act_addr  (act_addr),
  .sample    (sample)
);

// File: tb/par_result_port_tb_top.sv
`timescale 1ns/1ps
module par_result_port_tb_top;

  localparam int NREG = 8;
  localparam int AW   = 3;
  localparam int SLOT = 4;
  localparam int WAIT_MAX = 8 * SLOT;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NREG*32-1:0] regs_flat;
  logic              sel_load = 1'b0;
  logic [AW-1:0]     sel_addr = '0;
  logic [15:0]       bus_data;
  logic              word_hi;
  logic              bus_strb;

  logic [31:0] bank [NREG];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NREG; i++) regs_flat[i*32 +: 32] = bank[i];
  end

  par_result_port #(.NUM_REGS(NREG), .SLOT_CYCLES(SLOT)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .regs_i    (regs_flat),
    .sel_load_i(sel_load),
    .sel_addr_i(sel_addr),
    .bus_data_o(bus_data),
    .word_hi_o (word_hi),
    .bus_strb_o(bus_strb)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // wait for the strobe of a low word and check it
  task automatic low_word(input logic [31:0] exp, input string tag);
    bit seen = 0;
    for (int k = 0; k < WAIT_MAX && !seen; k++) begin
      @(negedge clk);
      if (bus_strb && !word_hi) seen = 1;
    end
    chk(seen, {tag, " low strobe seen R4"}, 32'(seen), 32'd1);
    chk(bus_data == exp[15:0], {tag, " low word R3"}, 32'(bus_data), 32'(exp[15:0]));
  endtask

  // follow the high word: lane lag, then strobed value, then strobe drop
  task automatic high_word(input logic [31:0] exp, input string tag);
    bit seen = 0;
    int gap = 0;
    for (int k = 0; k < WAIT_MAX && !seen; k++) begin
      @(negedge clk);
      if (word_hi) seen = 1;
    end
    chk(seen, {tag, " indicator high R3"}, 32'(seen), 32'd1);
    chk(bus_data[7:0] == exp[23:16], {tag, " lower lane first R5"}, 32'(bus_data[7:0]), 32'(exp[23:16]));
    chk(bus_data[15:8] == exp[15:8], {tag, " upper lane lags R5"}, 32'(bus_data[15:8]), 32'(exp[15:8]));
    chk(!bus_strb, {tag, " no strobe while lagging R4"}, 32'(bus_strb), 32'd0);
    @(negedge clk);
    chk(bus_data == exp[31:16], {tag, " upper lane settled R5"}, 32'(bus_data), 32'(exp[31:16]));
    seen = 0;
    for (int k = 0; k < WAIT_MAX && !seen; k++) begin
      if (bus_strb) seen = 1;
      else begin @(negedge clk); gap++; end
    end
    chk(gap == 1, {tag, " strobe position R4"}, 32'(gap), 32'd1);
    chk(bus_data == exp[31:16] && word_hi, {tag, " high word R3"}, 32'(bus_data), 32'(exp[31:16]));
    @(negedge clk);
    chk(!bus_strb, {tag, " strobe one clock R4"}, 32'(bus_strb), 32'd0);
  endtask

  task automatic pulse_sel(input logic [AW-1:0] a);
    sel_addr = a;
    sel_load = 1'b1;
    @(negedge clk);
    sel_load = 1'b0;
  endtask

  task automatic t_reset;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(bus_data == 16'h0 && !word_hi && !bus_strb, "reset outputs R1",
          {13'h0, bus_strb, word_hi, 1'b0, bus_data}, 32'h0);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_default;
    low_word(bank[0], "default addr0 R2");
    high_word(bank[0], "default addr0 R2");
    low_word(bank[0], "repeat R2");
    high_word(bank[0], "repeat R3");
  endtask

  task automatic t_coherent;
    logic [31:0] oldv = bank[0];
    logic [31:0] newv = 32'hC3A5_5A3C;
    low_word(oldv, "coherence R6");
    bank[0] = newv;
    high_word(oldv, "same sample R6");
    low_word(newv, "next sample R6");
    high_word(newv, "next sample R6");
  endtask

  task automatic t_sel_mid;
    low_word(bank[0], "mid select R7");
    pulse_sel(3'd3);
    high_word(bank[0], "pair kept R7");
    low_word(bank[3], "new addr R7");
    high_word(bank[3], "new addr R7");
  endtask

  task automatic t_last_wins;
    low_word(bank[3], "double select R8");
    pulse_sel(3'd5);
    pulse_sel(3'd6);
    low_word(bank[6], "last wins R8");
    high_word(bank[6], "last wins R8");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++)
      bank[i] = (32'h1357_9BDF * (i + 1)) ^ {4{8'(8'h11 * i + 8'h2C)}};
    t_reset();
    t_default();
    t_coherent();
    t_sel_mid();
    t_last_wins();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule